// File: doc/BRIEF.md
# SPI Target Serial Front End with Pause Control

This block is the pin-facing part of a memory-style SPI target. It samples chip select, serial clock, serial data in and an active-low pause input in the system clock domain and detects serial clock edges there. Incoming bits are collected most significant bit first, and each finished byte is handed to the core as a one-cycle strobe. Outgoing bytes that the core supplies are shifted onto a data-out pin that has a separate output enable, so the pad can float.

Both serial clock polarities in common use are accepted: idle-low (mode 0) and idle-high (mode 3). In both, input bits are taken on the rising edge and output bits change on the falling edge. The pause input lets a bus master stop a transfer part way through a byte and use the shared bus for something else. While paused, the clock and data-in pins are ignored, the output floats, and the partial byte is kept. Deselecting the target returns the front end to a clean start.

The core above the block decodes commands and supplies response bytes. It sees `tx_load_o` whenever the front end has taken `tx_data_i`, and it holds `tx_active_i` high while it wants the output pin driven. The system clock must run at least four times as fast as the serial clock.

Top module: `spi_hold_fe`

## Requirements
- R1: After reset, and while chip select is high, `spi_sdo_oe_o` is 0, `spi_sdo_o` is 0 and `rx_valid_o` is 0.
- R2: `spi_sdi_i` is sampled on rising serial clock edges, first bit in bit 7. Every 8th rising edge while selected, `rx_valid_o` goes high for exactly one system clock with the byte on `rx_data_o`.
- R3: Mode 0 (clock idles low) and mode 3 (clock idles high) give the same bytes in both directions. In mode 3, a falling edge that comes before the first rising edge of a byte leaves the output bit unchanged.
- R4: When chip select goes low, `tx_data_i` is loaded and its bit 7 appears on `spi_sdo_o`. Each falling edge that follows a rising edge moves the output to the next lower bit. The falling edge after the 8th rising edge loads a new `tx_data_i`. Every load pulses `tx_load_o` for one cycle.
- R5: `spi_sdo_oe_o` is 1 only while chip select is low, the block is not paused and `tx_active_i` is 1. `spi_sdo_o` reads 0 whenever `spi_sdo_oe_o` is 0.
- R6: The pause input is active low and acts only while chip select is low. If it goes low while the serial clock is low, the pause starts within 4 system clocks. If it goes low while the clock is high, the pause starts at the next falling edge, and that falling edge still moves the output bit.
- R7: If the pause input goes high while the serial clock is low, the pause ends within 4 system clocks. If it goes high while the clock is high, the pause ends at the next falling edge, and that falling edge does not move the output bit.
- R8: While paused, serial clock edges and `spi_sdi_i` have no effect. The partial bit count, the received bits and the pending output bit are kept, and the byte completes correctly after the pause.
- R9: Chip select going high at any time, including during a pause, clears the bit count, the pause state and the output enable. The next selection starts a fresh byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spi_cs_ni | input | 1 | Chip select pin, active low |
| spi_sck_i | input | 1 | Serial clock pin |
| spi_sdi_i | input | 1 | Serial data in pin |
| spi_hold_ni | input | 1 | Pause pin, active low |
| spi_sdo_o | output | 1 | Serial data out value |
| spi_sdo_oe_o | output | 1 | Output enable for the data out pad |
| tx_active_i | input | 1 | Core requests that the output be driven |
| tx_data_i | input | DATA_W | Next byte to transmit |
| tx_load_o | output | 1 | Pulse: `tx_data_i` has been taken |
| rx_data_o | output | DATA_W | Last received byte |
| rx_valid_o | output | 1 | Pulse: `rx_data_o` holds a new byte |

## Verification
A wrong bit count shows up as a `rx_valid_o` strobe on the wrong rising edge, or as a byte that is rotated by some bits. Either is visible within three system clocks of the edge concerned. A wrong pause state shows up within four system clocks of the pause pin or clock change: the output enable stays on when it should be off, or the reverse. It also shows up on the next data-out check after the pause ends, as a skipped or repeated output bit. Deselecting during a partial byte or during a pause, then sending a full byte, exposes any state that survives chip select going high.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

  typedef struct packed {
    logic cs_n;
    logic sck;
    logic sdi;
    logic hold_n;
  } spi_pins_t;

  localparam spi_pins_t PINS_IDLE = '{cs_n: 1'b1, sck: 1'b0, sdi: 1'b0, hold_n: 1'b1};

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync
  import spi_fe_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  spi_pins_t pins_i,
  output spi_pins_t pins_o,
  output logic      sck_rise_o,
  output logic      sck_fall_o,
  output logic      cs_fall_o
);

  spi_pins_t chain_q [STAGES];
  logic sck_q, cs_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= PINS_IDLE;
        else         chain_q[g] <= pins_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= PINS_IDLE;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign pins_o = chain_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= PINS_IDLE.sck;
      cs_q  <= PINS_IDLE.cs_n;
    end else begin
      sck_q <= pins_o.sck;
      cs_q  <= pins_o.cs_n;
    end
  end

  assign sck_rise_o = pins_o.sck & ~sck_q;
  assign sck_fall_o = ~pins_o.sck & sck_q;
  assign cs_fall_o  = ~pins_o.cs_n & cs_q;

endmodule

// File: rtl/spi_fe_hold.sv
module spi_fe_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic hold_n_i,
  output logic held_o
);

  // level-qualified: transitions only while the serial clock is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           held_o <= 1'b0;
    else if (cs_n_i)       held_o <= 1'b0;
    else if (!sck_i)       held_o <= ~hold_n_i;
  end

endmodule

// File: rtl/spi_fe_shift.sv
module spi_fe_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              cs_fall_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_bit_o,
  output logic              tx_load_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic [$clog2(DATA_W)-1:0] bit_cnt_o
);

  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [DATA_W-2:0] rx_sh_q;
  logic [DATA_W-1:0] tx_sh_q;
  logic              rise_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sh_q     <= '0;
      tx_sh_q     <= '0;
      rise_seen_q <= 1'b0;
      bit_cnt_o   <= '0;
      rx_data_o   <= '0;
      rx_valid_o  <= 1'b0;
      tx_load_o   <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      tx_load_o  <= 1'b0;
      if (cs_n_i) begin
        bit_cnt_o   <= '0;
        rise_seen_q <= 1'b0;
        tx_sh_q     <= '0;
      end else begin
        if (cs_fall_i) begin
          tx_sh_q   <= tx_data_i;
          tx_load_o <= 1'b1;
        end else if (fall_i && rise_seen_q) begin
          rise_seen_q <= 1'b0;
          if (bit_cnt_o == '0) begin
            tx_sh_q   <= tx_data_i;
            tx_load_o <= 1'b1;
          end else begin
            tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
          end
        end
        if (rise_i) begin
          rise_seen_q <= 1'b1;
          if (bit_cnt_o == LAST_BIT) begin
            rx_data_o  <= {rx_sh_q, sdi_i};
            rx_valid_o <= 1'b1;
            bit_cnt_o  <= '0;
          end else begin
            rx_sh_q   <= {rx_sh_q[DATA_W-3:0], sdi_i};
            bit_cnt_o <= bit_cnt_o + 1'b1;
          end
        end
      end
    end
  end

  assign tx_bit_o = tx_sh_q[DATA_W-1];

endmodule

// File: rtl/spi_hold_fe.sv
module spi_hold_fe
  import spi_fe_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spi_cs_ni,
  input  logic              spi_sck_i,
  input  logic              spi_sdi_i,
  input  logic              spi_hold_ni,
  output logic              spi_sdo_o,
  output logic              spi_sdo_oe_o,
  input  logic              tx_active_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_load_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o
);

  localparam int unsigned CNT_W = $clog2(DATA_W);

  spi_pins_t pins_a, pins_s;
  logic sck_rise, sck_fall, cs_fall;
  logic cs_s, sck_s, hold_s, held;
  logic act_rise, act_fall, tx_bit;
  logic [CNT_W-1:0] bit_cnt;

  assign pins_a = '{cs_n: spi_cs_ni, sck: spi_sck_i, sdi: spi_sdi_i, hold_n: spi_hold_ni};

  spi_fe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .pins_i     (pins_a),
    .pins_o     (pins_s),
    .sck_rise_o (sck_rise),
    .sck_fall_o (sck_fall),
    .cs_fall_o  (cs_fall)
  );

  assign cs_s   = pins_s.cs_n;
  assign sck_s  = pins_s.sck;
  assign hold_s = pins_s.hold_n;

  spi_fe_hold u_hold (
    .clk_i, .rst_ni,
    .cs_n_i   (cs_s),
    .sck_i    (sck_s),
    .hold_n_i (hold_s),
    .held_o   (held)
  );

  assign act_rise = sck_rise & ~held;
  assign act_fall = sck_fall & ~held;

  spi_fe_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni,
    .cs_n_i     (cs_s),
    .cs_fall_i  (cs_fall),
    .rise_i     (act_rise),
    .fall_i     (act_fall),
    .sdi_i      (pins_s.sdi),
    .tx_data_i  (tx_data_i),
    .tx_bit_o   (tx_bit),
    .tx_load_o  (tx_load_o),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o),
    .bit_cnt_o  (bit_cnt)
  );

  assign spi_sdo_oe_o = ~cs_s & ~held & tx_active_i;
  assign spi_sdo_o    = tx_bit & spi_sdo_oe_o;

endmodule

// File: rtl/spi_hold_fe_chk.sv
module spi_hold_fe_chk #(
  parameter int unsigned CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_s,
  input logic             sck_s,
  input logic             hold_s,
  input logic             held,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             rx_valid_o,
  input logic             spi_sdo_oe_o
);

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o); // R2

  AST_OE_OFF_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held |-> !spi_sdo_oe_o); // R5

  AST_HOLD_ENTRY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!held && !cs_s && !hold_s && !sck_s) |=> held); // R6

  AST_HOLD_EXIT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held && !cs_s && hold_s && !sck_s) |=> !held); // R7

  AST_HELD_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held && !cs_s) |=> $stable(bit_cnt)); // R8

  AST_NO_VALID_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held |=> !rx_valid_o); // R8

  AST_CS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> (bit_cnt == '0 && !held)); // R9

endmodule

bind spi_hold_fe spi_hold_fe_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cs_s         (cs_s),
  .sck_s        (sck_s),
  .hold_s       (hold_s),
  .held         (held),
  .bit_cnt      (bit_cnt),
  .rx_valid_o   (rx_valid_o),
  .spi_sdo_oe_o (spi_sdo_oe_o)
);

// File: tb/spi_hold_fe_tb_top.sv
module spi_hold_fe_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, hold_n = 1'b1, tx_active = 1'b0;
  logic [7:0] tx_data = '0;
  logic       sdo, sdo_oe, tx_load, rx_valid;
  logic [7:0] rx_data;

  int n_chk = 0, n_fail = 0, rx_cnt = 0, load_cnt = 0;
  logic [7:0] rx_last = '0;

  spi_hold_fe dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .spi_cs_ni    (cs_n),
    .spi_sck_i    (sck),
    .spi_sdi_i    (sdi),
    .spi_hold_ni  (hold_n),
    .spi_sdo_o    (sdo),
    .spi_sdo_oe_o (sdo_oe),
    .tx_active_i  (tx_active),
    .tx_data_i    (tx_data),
    .tx_load_o    (tx_load),
    .rx_data_o    (rx_data),
    .rx_valid_o   (rx_valid)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      rx_cnt++;
      rx_last = rx_data;
    end
    if (tx_load) load_cnt++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bit_cycle(input bit mode3, input logic din, input logic exp_do, input string req);
    if (mode3) sck = 1'b0;
    sdi = din;
    wclk(4);
    check(req, sdo, exp_do);
    sck = 1'b1;
    wclk(4);
    if (!mode3) sck = 1'b0;
  endtask

  task automatic xfer(input bit mode3, input logic [7:0] tx, input logic [7:0] rx,
                      input int hi, input int lo, input string req);
    for (int i = hi; i >= lo; i--) bit_cycle(mode3, rx[i], tx[i], req);
  endtask

  task automatic t_reset;
    check("R1 oe after reset", sdo_oe, 1'b0);
    check("R1 sdo after reset", sdo, 1'b0);
    check("R1 valid count after reset", rx_cnt, 0);
  endtask

  task automatic t_mode0;
    int rx0 = rx_cnt, ld0 = load_cnt;
    tx_active = 1'b1; tx_data = 8'hA5; sck = 1'b0;
    cs_n = 1'b0; wclk(4);
    check("R5 oe selected", sdo_oe, 1'b1);
    check("R4 load on select", load_cnt - ld0, 1);
    tx_data = 8'h3C;
    xfer(0, 8'hA5, 8'h5A, 7, 0, "R4 mode0 byte0 out");
    wclk(4);
    check("R2 mode0 rx count", rx_cnt - rx0, 1);
    check("R2 mode0 rx byte", rx_last, 8'h5A);
    check("R4 load at boundary", load_cnt - ld0, 2);
    xfer(0, 8'h3C, 8'hC3, 7, 0, "R4 mode0 byte1 out");
    wclk(4);
    check("R2 mode0 rx byte1", rx_last, 8'hC3);
    check("R2 mode0 rx count2", rx_cnt - rx0, 2);
    cs_n = 1'b1; wclk(4);
    check("R1 oe after deselect", sdo_oe, 1'b0);
  endtask

  task automatic t_mode3;
    int rx0 = rx_cnt;
    sck = 1'b1; wclk(4);
    tx_data = 8'h96;
    cs_n = 1'b0; wclk(4);
    tx_data = 8'h81;
    xfer(1, 8'h96, 8'hE7, 7, 0, "R3 mode3 byte0 out");
    wclk(4);
    check("R3 mode3 rx byte0", rx_last, 8'hE7);
    xfer(1, 8'h81, 8'h18, 7, 0, "R3 mode3 byte1 out");
    wclk(4);
    check("R3 mode3 rx byte1", rx_last, 8'h18);
    check("R3 mode3 rx count", rx_cnt - rx0, 2);
    cs_n = 1'b1; wclk(4);
    sck = 1'b0; wclk(4);
  endtask

  task automatic t_no_active;
    tx_active = 1'b0; tx_data = 8'hFF;
    cs_n = 1'b0; wclk(4);
    check("R5 oe without tx_active", sdo_oe, 1'b0);
    check("R5 sdo gated", sdo, 1'b0);
    cs_n = 1'b1; wclk(4);
    tx_active = 1'b1;
  endtask

  task automatic t_hold_low;
    int rx0 = rx_cnt;
    tx_data = 8'hC9;
    cs_n = 1'b0; wclk(4);
    xfer(0, 8'hC9, 8'h2D, 7, 6, "R4 pre-hold bits");
    wclk(4);
    hold_n = 1'b0; wclk(4);
    check("R6 held with sck low", sdo_oe, 1'b0);
    for (int k = 0; k < 3; k++) begin
      sdi = ~sdi; sck = 1'b1; wclk(4);
      sck = 1'b0; wclk(4);
    end
    check("R8 no byte while held", rx_cnt - rx0, 0);
    hold_n = 1'b1; wclk(4);
    check("R7 release with sck low", sdo_oe, 1'b1);
    check("R8 pending bit kept", sdo, 1'b0);
    xfer(0, 8'hC9, 8'h2D, 5, 0, "R8 post-hold bits");
    wclk(4);
    check("R8 byte after hold", rx_last, 8'h2D);
    check("R8 one byte after hold", rx_cnt - rx0, 1);
    cs_n = 1'b1; wclk(4);
  endtask

  task automatic t_hold_high;
    int rx0 = rx_cnt;
    tx_data = 8'h5B;
    cs_n = 1'b0; wclk(4);
    xfer(0, 8'h5B, 8'h6E, 7, 5, "R4 pre-hold bits");
    sdi = 1'b0; wclk(4);
    check("R4 bit4 out", sdo, 1'b1);
    sck = 1'b1; wclk(4);
    hold_n = 1'b0; wclk(4);
    check("R6 not held while sck high", sdo_oe, 1'b1);
    sck = 1'b0; wclk(4);
    check("R6 held after fall", sdo_oe, 1'b0);
    sdi = 1'b1; sck = 1'b1; wclk(4);
    sck = 1'b0; wclk(4);
    sck = 1'b1; wclk(4);
    hold_n = 1'b1; wclk(4);
    check("R7 still held while sck high", sdo_oe, 1'b0);
    sck = 1'b0; wclk(4);
    check("R7 released after fall", sdo_oe, 1'b1);
    check("R7 release fall does not shift", sdo, 1'b1);
    xfer(0, 8'h5B, 8'h6E, 3, 0, "R8 post-hold bits");
    wclk(4);
    check("R8 byte across high hold", rx_last, 8'h6E);
    check("R8 count across high hold", rx_cnt - rx0, 1);
    cs_n = 1'b1; wclk(4);
  endtask

  task automatic t_cs_abort;
    int rx0 = rx_cnt;
    tx_data = 8'hE1;
    cs_n = 1'b0; wclk(4);
    xfer(0, 8'hE1, 8'hFF, 7, 5, "R4 partial");
    cs_n = 1'b1; wclk(4);
    check("R9 oe after abort", sdo_oe, 1'b0);
    check("R9 no byte on abort", rx_cnt - rx0, 0);
    tx_data = 8'h4D;
    cs_n = 1'b0; wclk(4);
    xfer(0, 8'h4D, 8'h92, 7, 0, "R9 fresh byte out");
    wclk(4);
    check("R9 fresh byte in", rx_last, 8'h92);
    check("R9 fresh byte count", rx_cnt - rx0, 1);
    cs_n = 1'b1; wclk(4);
  endtask

  task automatic t_cs_in_hold;
    int rx0 = rx_cnt;
    tx_data = 8'h77;
    cs_n = 1'b0; wclk(4);
    xfer(0, 8'h77, 8'h00, 7, 6, "R4 partial");
    wclk(4);
    hold_n = 1'b0; wclk(4);
    check("R6 held before deselect", sdo_oe, 1'b0);
    cs_n = 1'b1; wclk(4);
    hold_n = 1'b1; wclk(4);
    tx_data = 8'hB4;
    cs_n = 1'b0; wclk(4);
    check("R9 pause cleared by deselect", sdo_oe, 1'b1);
    xfer(0, 8'hB4, 8'h3A, 7, 0, "R9 byte after hold abort");
    wclk(4);
    check("R9 rx after hold abort", rx_last, 8'h3A);
    check("R9 count after hold abort", rx_cnt - rx0, 1);
    cs_n = 1'b1; wclk(4);
  endtask

  initial begin
    wclk(3);
    rst_n = 1'b1;
    wclk(4);
    t_reset();
    t_mode0();
    t_mode3();
    t_no_active();
    t_hold_low();
    t_hold_high();
    t_cs_abort();
    t_cs_in_hold();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule